// File: doc/BRIEF.md
# Atomic Two-Way Arbitration Tree Node

This block is one node of a binary tree that lets several requesters share a single memory. It has two child-side ports and one parent-side port. Every port carries a request channel (address, write data, write enable, lock) and a response channel (read data), each with its own valid/ready handshake. Nodes stack into a tree, requesters at the leaves and the memory at the root, so the number of hops grows with the logarithm of the requester count. Every request, read or write, gets exactly one response.

The node holds one transaction at a time. A state machine with four states controls it. `ST_FREE` accepts a request from either child. `ST_HELD` accepts a request only from the child that currently owns the node. `ST_ISSUE` presents the captured request to the parent. `ST_WAIT` steers the parent's response back to the child that issued it. The transitions are:

- `ST_FREE`/`ST_HELD` → `ST_ISSUE` when a child request is accepted.
- `ST_ISSUE` → `ST_WAIT` when the parent accepts the request.
- `ST_WAIT` → `ST_HELD` when a response completes for a request that had lock=1.
- `ST_WAIT` → `ST_FREE` when a response completes for a request that had lock=0.

A requester makes a read-modify-write atomic by sending its read with lock=1 and its write with lock=0. The lock travels upward with the request, so every node on the path stays reserved for that requester until the unlocking write completes.

Top module: `arb_tree_node`

## Requirements
- R1: After reset, `up_req_valid`, `c0_rsp_valid`, `c1_rsp_valid` and both `c*_req_ready` are 0 until a child presents a request. Round-robin priority starts at child 0.
- R2: In `ST_FREE` with exactly one child valid, that child's `req_ready` is 1 in the same cycle. `req_ready` is never 1 toward a child whose `req_valid` is 0. In the cycle after acceptance, `up_req_valid` is 1 and `up_req_addr`, `up_req_wdata` and `up_req_we` equal the accepted values.
- R3: With both children valid and no owner, the accepted child alternates between 0 and 1, and child 0 wins the first such contest after reset.
- R4: While `up_req_valid` is 1 and `up_req_ready` is 0, the upward request and its fields stay unchanged in the next cycle.
- R5: From a child acceptance until the handshake of the matching upward response, both `c*_req_ready` stay 0.
- R6: Only the child that issued the outstanding request sees `rsp_valid`. Its `rsp_rdata` equals `up_rsp_rdata`, and `up_rsp_ready` equals that child's `rsp_ready`. Outside `ST_WAIT`, `up_rsp_ready` is 0.
- R7: After a request with lock=1 completes, only the same child is accepted, even when the other child is valid. This lasts until a lock=0 request from that child completes. Concurrent read-then-increment sequences therefore never lose an update.
- R8: `up_req_lock` equals the lock value of the accepted child request.
- R9: When ownership ends and the other child is waiting, the other child is accepted next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c0_req_valid | input | 1 | Child 0 request valid |
| c0_req_ready | output | 1 | Child 0 request accepted |
| c0_req_addr | input | ADDR_W | Child 0 address |
| c0_req_wdata | input | DATA_W | Child 0 write data |
| c0_req_we | input | 1 | Child 0 write enable |
| c0_req_lock | input | 1 | Child 0 keeps ownership after this request |
| c0_rsp_valid | output | 1 | Response valid toward child 0 |
| c0_rsp_ready | input | 1 | Child 0 takes the response |
| c0_rsp_rdata | output | DATA_W | Response data toward child 0 |
| c1_req_valid | input | 1 | Child 1 request valid |
| c1_req_ready | output | 1 | Child 1 request accepted |
| c1_req_addr | input | ADDR_W | Child 1 address |
| c1_req_wdata | input | DATA_W | Child 1 write data |
| c1_req_we | input | 1 | Child 1 write enable |
| c1_req_lock | input | 1 | Child 1 keeps ownership after this request |
| c1_rsp_valid | output | 1 | Response valid toward child 1 |
| c1_rsp_ready | input | 1 | Child 1 takes the response |
| c1_rsp_rdata | output | DATA_W | Response data toward child 1 |
| up_req_valid | output | 1 | Upward request valid |
| up_req_ready | input | 1 | Parent accepts the request |
| up_req_addr | output | ADDR_W | Upward address |
| up_req_wdata | output | DATA_W | Upward write data |
| up_req_we | output | 1 | Upward write enable |
| up_req_lock | output | 1 | Upward lock flag |
| up_rsp_valid | input | 1 | Parent response valid |
| up_rsp_ready | output | 1 | Node takes the parent response |
| up_rsp_rdata | input | DATA_W | Parent response data |

## Verification
The bench targets contention in the cycle right after a release. Here the waiting child must win (R9). A node that forgot to move its priority would hand the grant straight back to the former owner, and a node that dropped ownership early would let the other child's write land between a locked read and its write. A node that lost the interleaving this way would end with a shared counter below the number of completed increments.

The bench also stalls the parent and the children's response-ready signals at random. This exposes a node that changes its upward fields during a stall, that accepts a second request while one is outstanding, or that shows a response to the wrong child or with the wrong backpressure.

// File: rtl/arb_node_pkg.sv
package arb_node_pkg;
    localparam int unsigned NUM_CHILD = 2;

    typedef logic [0:0] child_id_t;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_HELD  = 2'd1,
        ST_ISSUE = 2'd2,
        ST_WAIT  = 2'd3
    } node_state_t;
endpackage

// File: rtl/arb_node_pick.sv
module arb_node_pick
    import arb_node_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CHILD-1:0] req_valid,
    input  logic                 open,
    input  logic                 hold,
    input  child_id_t            owner,
    output logic [NUM_CHILD-1:0] grant,
    output child_id_t            grant_id
);
    child_id_t prio_q;

    // Choice of the child that may hand over a request this cycle
    always_comb begin
        grant    = '0;
        grant_id = prio_q;
        if (open) begin
            if (hold) begin
                grant[owner] = req_valid[owner];
                grant_id     = owner;
            end else if (&req_valid) begin
                grant[prio_q] = 1'b1;
                grant_id      = prio_q;
            end else if (req_valid[1]) begin
                grant[1] = 1'b1;
                grant_id = 1'b1;
            end else if (req_valid[0]) begin
                grant[0] = 1'b1;
                grant_id = 1'b0;
            end
        end
    end

    // Priority moves to the other child after every grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else if (|grant) begin
            prio_q <= ~grant_id;
        end
    end

    p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_grant_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req_valid) == '0);

    p_held_owner_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !grant[~owner]);
endmodule

// File: rtl/arb_node_fsm.sv
module arb_node_fsm
    import arb_node_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take,
    input  logic        lock_held,
    input  logic        up_ready,
    input  logic        rsp_fire,
    output node_state_t state,
    output logic        open,
    output logic        hold,
    output logic        issue,
    output logic        rsp_phase
);
    node_state_t state_q;
    node_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE:  if (take) state_d = ST_ISSUE;
            ST_HELD:  if (take) state_d = ST_ISSUE;
            ST_ISSUE: if (up_ready) state_d = ST_WAIT;
            ST_WAIT:  if (rsp_fire) state_d = lock_held ? ST_HELD : ST_FREE;
            default:  state_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        open      = 1'b0;
        hold      = 1'b0;
        issue     = 1'b0;
        rsp_phase = 1'b0;
        unique case (state_q)
            ST_FREE:  open = 1'b1;
            ST_HELD:  begin open = 1'b1; hold = 1'b1; end
            ST_ISSUE: issue = 1'b1;
            ST_WAIT:  rsp_phase = 1'b1;
            default:  open = 1'b0;
        endcase
    end

    assign state = state_q;

    p_take_then_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> issue);

    p_stall_keeps_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !up_ready) |=> issue);

    p_locked_done_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_phase && rsp_fire && lock_held) |=> hold);
endmodule

// File: rtl/arb_node_route.sv
module arb_node_route
    import arb_node_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CHILD-1:0] grant,
    input  child_id_t            grant_id,
    input  logic [ADDR_W-1:0]    c_addr  [NUM_CHILD],
    input  logic [DATA_W-1:0]    c_wdata [NUM_CHILD],
    input  logic [NUM_CHILD-1:0] c_we,
    input  logic [NUM_CHILD-1:0] c_lock,
    input  logic                 issue,
    input  logic                 up_ready,
    input  logic                 rsp_phase,
    input  logic                 up_rsp_valid,
    input  logic [NUM_CHILD-1:0] c_rsp_ready,
    output logic [ADDR_W-1:0]    up_addr,
    output logic [DATA_W-1:0]    up_wdata,
    output logic                 up_we,
    output logic                 up_lock,
    output child_id_t            sel,
    output logic [NUM_CHILD-1:0] c_rsp_valid,
    output logic                 up_rsp_ready
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;
    logic              lock_q;
    child_id_t         sel_q;

    // Capture of the accepted request; held until the next acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            lock_q  <= 1'b0;
            sel_q   <= '0;
        end else if (|grant) begin
            addr_q  <= c_addr[grant_id];
            wdata_q <= c_wdata[grant_id];
            we_q    <= c_we[grant_id];
            lock_q  <= c_lock[grant_id];
            sel_q   <= grant_id;
        end
    end

    generate
        for (genvar g = 0; g < NUM_CHILD; g++) begin : g_rsp_steer
            assign c_rsp_valid[g] = rsp_phase && up_rsp_valid && (sel_q == child_id_t'(g));
        end
    endgenerate

    assign up_rsp_ready = rsp_phase && c_rsp_ready[sel_q];
    assign up_addr      = addr_q;
    assign up_wdata     = wdata_q;
    assign up_we        = we_q;
    assign up_lock      = lock_q;
    assign sel          = sel_q;

    p_fields_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !up_ready) |=> ($stable(addr_q) && $stable(wdata_q) &&
                                  $stable(we_q) && $stable(lock_q)));

    p_rsp_single_child_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(c_rsp_valid));

    p_rsp_needs_upstream_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|c_rsp_valid) |-> up_rsp_valid);
endmodule

// File: rtl/arb_tree_node.sv
module arb_tree_node
    import arb_node_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c0_req_valid,
    output logic              c0_req_ready,
    input  logic [ADDR_W-1:0] c0_req_addr,
    input  logic [DATA_W-1:0] c0_req_wdata,
    input  logic              c0_req_we,
    input  logic              c0_req_lock,
    output logic              c0_rsp_valid,
    input  logic              c0_rsp_ready,
    output logic [DATA_W-1:0] c0_rsp_rdata,
    input  logic              c1_req_valid,
    output logic              c1_req_ready,
    input  logic [ADDR_W-1:0] c1_req_addr,
    input  logic [DATA_W-1:0] c1_req_wdata,
    input  logic              c1_req_we,
    input  logic              c1_req_lock,
    output logic              c1_rsp_valid,
    input  logic              c1_rsp_ready,
    output logic [DATA_W-1:0] c1_rsp_rdata,
    output logic              up_req_valid,
    input  logic              up_req_ready,
    output logic [ADDR_W-1:0] up_req_addr,
    output logic [DATA_W-1:0] up_req_wdata,
    output logic              up_req_we,
    output logic              up_req_lock,
    input  logic              up_rsp_valid,
    output logic              up_rsp_ready,
    input  logic [DATA_W-1:0] up_rsp_rdata
);
    logic [NUM_CHILD-1:0] req_valid;
    logic [NUM_CHILD-1:0] grant;
    child_id_t            grant_id;
    child_id_t            sel;
    logic [ADDR_W-1:0]    c_addr  [NUM_CHILD];
    logic [DATA_W-1:0]    c_wdata [NUM_CHILD];
    logic [NUM_CHILD-1:0] c_we;
    logic [NUM_CHILD-1:0] c_lock;
    logic [NUM_CHILD-1:0] c_rsp_ready;
    logic [NUM_CHILD-1:0] c_rsp_valid;
    node_state_t          state;
    logic                 open;
    logic                 hold;
    logic                 issue;
    logic                 rsp_phase;
    logic                 rsp_fire;

    assign req_valid   = {c1_req_valid, c0_req_valid};
    assign c_addr[0]   = c0_req_addr;
    assign c_addr[1]   = c1_req_addr;
    assign c_wdata[0]  = c0_req_wdata;
    assign c_wdata[1]  = c1_req_wdata;
    assign c_we        = {c1_req_we, c0_req_we};
    assign c_lock      = {c1_req_lock, c0_req_lock};
    assign c_rsp_ready = {c1_rsp_ready, c0_rsp_ready};

    arb_node_pick u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .open      (open),
        .hold      (hold),
        .owner     (sel),
        .grant     (grant),
        .grant_id  (grant_id)
    );

    arb_node_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (|grant),
        .lock_held (up_req_lock),
        .up_ready  (up_req_ready),
        .rsp_fire  (rsp_fire),
        .state     (state),
        .open      (open),
        .hold      (hold),
        .issue     (issue),
        .rsp_phase (rsp_phase)
    );

    arb_node_route #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .grant        (grant),
        .grant_id     (grant_id),
        .c_addr       (c_addr),
        .c_wdata      (c_wdata),
        .c_we         (c_we),
        .c_lock       (c_lock),
        .issue        (issue),
        .up_ready     (up_req_ready),
        .rsp_phase    (rsp_phase),
        .up_rsp_valid (up_rsp_valid),
        .c_rsp_ready  (c_rsp_ready),
        .up_addr      (up_req_addr),
        .up_wdata     (up_req_wdata),
        .up_we        (up_req_we),
        .up_lock      (up_req_lock),
        .sel          (sel),
        .c_rsp_valid  (c_rsp_valid),
        .up_rsp_ready (up_rsp_ready)
    );

    assign rsp_fire     = up_rsp_valid && up_rsp_ready;
    assign up_req_valid = issue;
    assign c0_req_ready = grant[0];
    assign c1_req_ready = grant[1];
    assign c0_rsp_valid = c_rsp_valid[0];
    assign c1_rsp_valid = c_rsp_valid[1];
    assign c0_rsp_rdata = up_rsp_rdata;
    assign c1_rsp_rdata = up_rsp_rdata;

    p_busy_no_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ISSUE || state == ST_WAIT) |-> !(c0_req_ready || c1_req_ready));

    p_lock_forwarded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_req_valid) |-> up_req_lock == $past(c0_req_ready ? c0_req_lock : c1_req_lock));

    p_addr_forwarded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_req_valid) |-> up_req_addr == $past(c0_req_ready ? c0_req_addr : c1_req_addr));
endmodule

// File: tb/arb_tree_node_tb_top.sv
`timescale 1ns/1ps
module arb_tree_node_tb_top;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CNT_ADDR = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          c0_req_valid = 0, c1_req_valid = 0;
    logic          c0_req_ready, c1_req_ready;
    logic [AW-1:0] c0_req_addr = '0, c1_req_addr = '0;
    logic [DW-1:0] c0_req_wdata = '0, c1_req_wdata = '0;
    logic          c0_req_we = 0, c1_req_we = 0, c0_req_lock = 0, c1_req_lock = 0;
    logic          c0_rsp_valid, c1_rsp_valid;
    logic          c0_rsp_ready = 0, c1_rsp_ready = 0;
    logic [DW-1:0] c0_rsp_rdata, c1_rsp_rdata;
    logic          up_req_valid, up_req_ready = 0;
    logic [AW-1:0] up_req_addr;
    logic [DW-1:0] up_req_wdata;
    logic          up_req_we, up_req_lock;
    logic          up_rsp_valid = 0, up_rsp_ready;
    logic [DW-1:0] up_rsp_rdata = '0;

    arb_tree_node #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bench-side memory and reference model
    logic [DW-1:0] mem [16];
    bit busy = 0, issued = 0, locked = 0;
    int inflight = 0, owner = 0, prio = 0;
    logic [AW-1:0] s_addr; logic [DW-1:0] s_wdata; bit s_we, s_lock;
    bit mem_pend = 0; int mem_delay = 0; logic [DW-1:0] mem_rd = '0;
    int expect_next = -1;
    int first_grant = -1, last_acc = -1;
    int rmw_done = 0;

    // Child generators
    bit cv [2]; logic [AW-1:0] ca [2]; logic [DW-1:0] cw [2]; bit cwe [2]; bit clk_l [2];
    bit wait_rsp [2]; bit rmw_next [2]; bit in_rmw [2]; logic [DW-1:0] rmw_val [2];
    int p_new [2]; int rmw_pct [2];
    bit ready_always = 1;
    bit check_alt = 0;

    function automatic bit exp_ready(input int i);
        if (busy || !cv[i]) return 0;
        if (locked) return owner == i;
        if (cv[1-i]) return prio == i;
        return 1;
    endfunction

    task automatic cycle();
        bit rdy [2]; bit crv [2]; logic [DW-1:0] crd [2]; bit crr [2];
        bit req_hs, rsp_hs; int acc;
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            if (!cv[i] && !wait_rsp[i]) begin
                if (rmw_next[i]) begin
                    cv[i] = 1; ca[i] = AW'(CNT_ADDR); cw[i] = rmw_val[i]; cwe[i] = 1; clk_l[i] = 0;
                    rmw_next[i] = 0;
                end else if (int'($urandom % 100) < p_new[i]) begin
                    cv[i] = 1;
                    if (int'($urandom % 100) < rmw_pct[i]) begin
                        ca[i] = AW'(CNT_ADDR); cw[i] = $urandom; cwe[i] = 0; clk_l[i] = 1; in_rmw[i] = 1;
                    end else begin
                        ca[i] = AW'($urandom % 16);
                        if (ca[i] == AW'(CNT_ADDR)) ca[i] = AW'(CNT_ADDR + 1);
                        cw[i] = $urandom; cwe[i] = $urandom % 2; clk_l[i] = 0;
                    end
                end
            end
        end
        c0_req_valid = cv[0]; c0_req_addr = ca[0]; c0_req_wdata = cw[0]; c0_req_we = cwe[0]; c0_req_lock = clk_l[0];
        c1_req_valid = cv[1]; c1_req_addr = ca[1]; c1_req_wdata = cw[1]; c1_req_we = cwe[1]; c1_req_lock = clk_l[1];
        up_req_ready = ready_always ? 1'b1 : 1'($urandom % 2);
        c0_rsp_ready = ready_always ? 1'b1 : 1'($urandom % 2);
        c1_rsp_ready = ready_always ? 1'b1 : 1'($urandom % 2);
        up_rsp_valid = mem_pend && (mem_delay == 0);
        up_rsp_rdata = up_rsp_valid ? mem_rd : DW'($urandom);
        #1;
        rdy[0] = c0_req_ready; rdy[1] = c1_req_ready;
        crv[0] = c0_rsp_valid; crv[1] = c1_rsp_valid;
        crd[0] = c0_rsp_rdata; crd[1] = c1_rsp_rdata;
        crr[0] = c0_rsp_ready; crr[1] = c1_rsp_ready;
        for (int i = 0; i < 2; i++) begin
            if (busy) chk(rdy[i] == 0, "R5 ready while busy", rdy[i], 0);
            else if (locked) chk(rdy[i] == exp_ready(i), "R7 owner-only ready", rdy[i], exp_ready(i));
            else if (cv[0] && cv[1]) chk(rdy[i] == exp_ready(i), "R3 round-robin ready", rdy[i], exp_ready(i));
            else chk(rdy[i] == exp_ready(i), "R2 single-child ready", rdy[i], exp_ready(i));
        end
        chk(up_req_valid == (busy && !issued), "R2 up_req_valid", up_req_valid, busy && !issued);
        if (busy && !issued && up_req_valid) begin
            chk(up_req_addr == s_addr && up_req_wdata == s_wdata && up_req_we == s_we,
                "R2/R4 upward fields", {up_req_addr, up_req_we}, {s_addr, s_we});
            chk(up_req_lock == s_lock, "R8 lock forwarded", up_req_lock, s_lock);
        end
        for (int j = 0; j < 2; j++) begin
            bit ev;
            ev = busy && issued && up_rsp_valid && inflight == j;
            chk(crv[j] == ev, "R6 rsp_valid steering", crv[j], ev);
            if (ev) chk(crd[j] == up_rsp_rdata, "R6 rsp data", crd[j], up_rsp_rdata);
        end
        chk(up_rsp_ready == ((busy && issued) ? crr[inflight] : 1'b0), "R6 up_rsp_ready",
            up_rsp_ready, (busy && issued) ? crr[inflight] : 1'b0);
        // Model updates for the events of the coming edge
        req_hs = up_req_valid && up_req_ready;
        rsp_hs = up_rsp_valid && up_rsp_ready;
        acc = -1;
        for (int i = 0; i < 2; i++) if (cv[i] && rdy[i]) acc = i;
        if (rsp_hs) begin
            if (locked && !s_lock && cv[1-inflight]) expect_next = 1 - inflight;
            busy = 0; mem_pend = 0;
            locked = s_lock; owner = inflight;
            wait_rsp[inflight] = 0;
            if (in_rmw[inflight]) begin
                if (s_lock) begin
                    rmw_next[inflight] = 1; rmw_val[inflight] = crd[inflight] + 1;
                end else begin
                    in_rmw[inflight] = 0; rmw_done++;
                end
            end
        end
        if (req_hs && busy && !issued) begin
            issued = 1;
            mem_rd = mem[s_addr[3:0]];
            if (s_we) mem[s_addr[3:0]] = s_wdata;
            mem_pend = 1;
            mem_delay = ready_always ? 0 : int'($urandom % 3);
        end else if (mem_pend && mem_delay > 0) begin
            mem_delay--;
        end
        if (acc >= 0) begin
            if (first_grant < 0) begin
                first_grant = acc;
                chk(acc == 0, "R3 first contest to child 0", acc, 0);
            end
            if (expect_next >= 0) begin
                chk(acc == expect_next, "R9 waiting child after release", acc, expect_next);
                expect_next = -1;
            end
            if (check_alt && last_acc >= 0)
                chk(acc != last_acc, "R3 alternation", acc, 1 - last_acc);
            last_acc = acc;
            busy = 1; issued = 0; inflight = acc; prio = 1 - acc;
            s_addr = ca[acc]; s_wdata = cw[acc]; s_we = cwe[acc]; s_lock = clk_l[acc];
            cv[acc] = 0; wait_rsp[acc] = 1;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        $urandom(32'h5eed_0017);
        for (int k = 0; k < 16; k++) mem[k] = '0;
        for (int i = 0; i < 2; i++) begin
            cv[i] = 0; wait_rsp[i] = 0; rmw_next[i] = 0; in_rmw[i] = 0;
            p_new[i] = 0; rmw_pct[i] = 0; clk_l[i] = 0; cwe[i] = 0; ca[i] = '0; cw[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk(up_req_valid == 0, "R1 up_req_valid reset", up_req_valid, 0);
        chk(c0_rsp_valid == 0 && c1_rsp_valid == 0, "R1 rsp_valid reset", {c1_rsp_valid, c0_rsp_valid}, 0);
        chk(c0_req_ready == 0 && c1_req_ready == 0, "R1 req_ready reset", {c1_req_ready, c0_req_ready}, 0);
        // Directed: constant contention, plain accesses, no stalls
        ready_always = 1; check_alt = 1;
        p_new[0] = 100; p_new[1] = 100;
        repeat (60) cycle();
        check_alt = 0;
        // Directed: child 0 performs locked sequences while child 1 keeps asking
        rmw_pct[0] = 100;
        repeat (200) cycle();
        // Random mix with stalls on both sides
        ready_always = 0;
        p_new[0] = 40; p_new[1] = 40; rmw_pct[0] = 30; rmw_pct[1] = 30;
        repeat (4000) cycle();
        // Both children contend with locked sequences only
        p_new[0] = 70; p_new[1] = 70; rmw_pct[0] = 100; rmw_pct[1] = 100;
        repeat (2000) cycle();
        // Drain
        p_new[0] = 0; p_new[1] = 0;
        for (int n = 0; n < 400; n++) begin
            if (!busy && !cv[0] && !cv[1] && !rmw_next[0] && !rmw_next[1]) break;
            cycle();
        end
        chk(mem[CNT_ADDR] == DW'(rmw_done), "R7 atomic counter total", mem[CNT_ADDR], rmw_done);
        chk(rmw_done > 20, "R7 enough locked sequences", rmw_done, 21);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule